// File: doc/BRIEF.md
# Block-Mode DMA Transfer Sequencer

This engine copies data between two memory regions one block at a time. Software sets the source address, destination address, unit size, block length and number of blocks through configuration inputs, then strobes a load. Each trigger then moves one complete block of units over a single-beat memory port and returns to idle. Every unit is a read from the source followed by a write of the same data to the destination.

A mode bit marks one side as the repeating block area. That side walks upward through the block one unit at a time. At the end of every block it returns to where the block began, and the per-block counter reloads. The other side's address stays put during a block. It moves once per block, up or down by one unit, or it does not move at all. A count of remaining blocks is kept, and an interrupt is raised when the last block finishes. The interrupt stays high until it is acknowledged.

Top module: `blk_xfer_seq`

## Requirements
- R1: One trigger (`trig_i` high for one cycle while idle and armed) transfers exactly one full block, after which `busy_o` falls and the engine waits in idle.
- R2: A trigger that arrives while a block is in progress, or while the engine is not armed, is ignored. The engine is armed by `cfg_load_i` and disarmed when the last block completes. `cfg_load_i` is ignored while busy.
- R3: The mode bit `cfg_blk_src_i` set to 1 makes the source address the block area. Set to 0, it makes the destination address the block area.
- R4: Unit code `cfg_unit_i` 0, 1 and 2 selects 1, 2 and 4 bytes. Code 3 acts as 4 bytes. Within a block, the block-side address rises by the unit size after each unit is written.
- R5: The block length `cfg_blk_size_i` is 1 to 256 units, and the value 0 means 256. At each block end, `blk_ctr_o` reloads to the stored length and `blk_size_o` is unchanged.
- R6: At each block end, the block-side address is restored to its value at the start of that block.
- R7: The other side's address does not change within a block. At block end it moves by one unit size according to its direction code: 0 fixed, 1 increment, 2 decrement, 3 fixed.
- R8: The block count `cfg_blk_cnt_i` is 1 to 65,536 blocks, and the value 0 means 65,536. `blk_left_o` drops by one after each completed block.
- R9: Each unit is a read of the source address followed by a write of the read data to the destination address. Each access holds until `mem_rdy_i` is high.
- R10: `irq_o` rises when the last block completes. It stays high until `irq_ack_i` is seen, and it does not rise after earlier blocks.
- R11: After reset the engine is idle and unarmed, with `busy_o`, `mem_req_o` and `irq_o` low and all counters zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Load configuration and arm (idle only) |
| cfg_src_addr_i | input | AW | Source start address |
| cfg_dst_addr_i | input | AW | Destination start address |
| cfg_unit_i | input | 2 | Unit size code |
| cfg_blk_src_i | input | 1 | 1: source is block area, 0: destination |
| cfg_src_dir_i | input | 2 | Source direction when it is not the block side |
| cfg_dst_dir_i | input | 2 | Destination direction when it is not the block side |
| cfg_blk_size_i | input | 8 | Units per block, 0 = 256 |
| cfg_blk_cnt_i | input | 16 | Number of blocks, 0 = 65,536 |
| trig_i | input | 1 | Start one block |
| busy_o | output | 1 | Block in progress |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | AW | Access address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data |
| mem_rdy_i | input | 1 | Access complete |
| irq_o | output | 1 | All blocks done |
| irq_ack_i | input | 1 | Clears the interrupt |
| src_addr_o | output | AW | Current source address |
| dst_addr_o | output | AW | Current destination address |
| blk_size_o | output | 8 | Stored block length |
| blk_ctr_o | output | 8 | Units left in the current block |
| blk_left_o | output | 16 | Blocks remaining |

## Verification
The assertions watch the local invariants on every cycle. They check that idle holds without a valid trigger and that the write data equals the data just read. They also cover the counter reload, the count decrement and the block-side restore at block end, the non-block address holding still within a block, and the interrupt being set on the last block and held until acknowledged. Only the bench scenarios show the end-to-end effects. These are the exact address sequences for each unit size, mode and direction, the 256-unit and 65,536-block encodings, and stalled ready handshakes. They also include ignored triggers and loads, which are seen at the ports as the absence of extra transfers.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} state_e;

  localparam logic [1:0] DIR_INC = 2'd1;
  localparam logic [1:0] DIR_DEC = 2'd2;

  function automatic logic [2:0] unit_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/xfer_addr_reg.sv
module xfer_addr_reg #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          is_blk_i,
  input  logic [1:0]    dir_i,
  input  logic [2:0]    step_i,
  input  logic          unit_done_i,
  input  logic          blk_end_i,
  output logic [AW-1:0] addr_o
);
  import blk_xfer_pkg::*;

  logic [AW-1:0] addr_q, base_q, step_w;
  assign step_w = AW'(step_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      base_q <= '0;
    end else if (load_i) begin
      addr_q <= load_val_i;
      base_q <= load_val_i;
    end else if (blk_end_i) begin
      if (is_blk_i) begin
        addr_q <= base_q;
      end else if (dir_i == DIR_INC) begin
        addr_q <= addr_q + step_w;
        base_q <= addr_q + step_w;
      end else if (dir_i == DIR_DEC) begin
        addr_q <= addr_q - step_w;
        base_q <= addr_q - step_w;
      end
    end else if (unit_done_i && is_blk_i) begin
      addr_q <= addr_q + step_w;
    end
  end

  assign addr_o = addr_q;

  a_r6_blk_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_end_i && is_blk_i && !load_i) |=> addr_q == $past(base_q));
  a_r7_nonblk_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !blk_end_i && !is_blk_i) |=> $stable(addr_q));
endmodule

// File: rtl/xfer_counters.sv
module xfer_counters #(
  parameter int SW = 8,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [SW-1:0] size_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          unit_done_i,
  input  logic          blk_end_i,
  input  logic          irq_ack_i,
  output logic [SW-1:0] size_o,
  output logic [SW-1:0] ctr_o,
  output logic [CW-1:0] left_o,
  output logic          last_unit_o,
  output logic          armed_o,
  output logic          irq_o
);
  logic [SW-1:0] size_q, ctr_q;
  logic [CW-1:0] left_q;
  logic          armed_q, irq_q, last_blk;

  assign last_unit_o = (ctr_q == SW'(1));
  assign last_blk    = (left_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q  <= '0;
      ctr_q   <= '0;
      left_q  <= '0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (load_i) begin
        size_q  <= size_i;
        ctr_q   <= size_i;
        left_q  <= cnt_i;
        armed_q <= 1'b1;
      end else if (blk_end_i) begin
        ctr_q  <= size_q;
        left_q <= left_q - CW'(1);
        if (last_blk) armed_q <= 1'b0;
      end else if (unit_done_i) begin
        ctr_q <= ctr_q - SW'(1);
      end
      if (blk_end_i && last_blk) irq_q <= 1'b1;
      else if (irq_ack_i)        irq_q <= 1'b0;
    end
  end

  assign size_o  = size_q;
  assign ctr_o   = ctr_q;
  assign left_o  = left_q;
  assign armed_o = armed_q;
  assign irq_o   = irq_q;

  a_r5_ctr_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_end_i && !load_i) |=> (ctr_q == size_q && $stable(size_q)));
  a_r8_left_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_end_i && !load_i) |=> left_q == CW'($past(left_q) - CW'(1)));
  a_r10_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_end_i && last_blk) |=> irq_q);
  a_r10_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_ack_i) |=> irq_q);
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SW = 8,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_load_i,
  input  logic [AW-1:0] cfg_src_addr_i,
  input  logic [AW-1:0] cfg_dst_addr_i,
  input  logic [1:0]    cfg_unit_i,
  input  logic          cfg_blk_src_i,
  input  logic [1:0]    cfg_src_dir_i,
  input  logic [1:0]    cfg_dst_dir_i,
  input  logic [SW-1:0] cfg_blk_size_i,
  input  logic [CW-1:0] cfg_blk_cnt_i,
  input  logic          trig_i,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_rdy_i,
  output logic          irq_o,
  input  logic          irq_ack_i,
  output logic [AW-1:0] src_addr_o,
  output logic [AW-1:0] dst_addr_o,
  output logic [SW-1:0] blk_size_o,
  output logic [SW-1:0] blk_ctr_o,
  output logic [CW-1:0] blk_left_o
);
  import blk_xfer_pkg::*;

  localparam int NSIDE = 2; // 0 source, 1 destination

  state_e        state_q, state_d;
  logic          blk_src_q;
  logic [1:0]    unit_q, src_dir_q, dst_dir_q;
  logic [DW-1:0] data_q;
  logic          cfg_ld, start, unit_done, blk_end, last_unit, armed;
  logic [AW-1:0] side_addr [NSIDE];

  assign cfg_ld    = cfg_load_i && (state_q == ST_IDLE);
  assign start     = trig_i && armed && (state_q == ST_IDLE);
  assign unit_done = (state_q == ST_WR) && mem_rdy_i;
  assign blk_end   = unit_done && last_unit;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_RD;
      ST_RD:   if (mem_rdy_i) state_d = ST_WR;
      ST_WR:   if (mem_rdy_i) state_d = last_unit ? ST_IDLE : ST_RD;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      blk_src_q <= 1'b0;
      unit_q    <= '0;
      src_dir_q <= '0;
      dst_dir_q <= '0;
      data_q    <= '0;
    end else begin
      state_q <= state_d;
      if (cfg_ld) begin
        blk_src_q <= cfg_blk_src_i;
        unit_q    <= cfg_unit_i;
        src_dir_q <= cfg_src_dir_i;
        dst_dir_q <= cfg_dst_dir_i;
      end
      if (state_q == ST_RD && mem_rdy_i) data_q <= mem_rdata_i;
    end
  end

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    logic blk_side;
    assign blk_side = (g == 0) ? blk_src_q : !blk_src_q;
    xfer_addr_reg #(.AW(AW)) u_addr (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (cfg_ld),
      .load_val_i  ((g == 0) ? cfg_src_addr_i : cfg_dst_addr_i),
      .is_blk_i    (blk_side),
      .dir_i       ((g == 0) ? src_dir_q : dst_dir_q),
      .step_i      (unit_bytes(unit_q)),
      .unit_done_i (unit_done),
      .blk_end_i   (blk_end),
      .addr_o      (side_addr[g])
    );
  end

  xfer_counters #(.SW(SW), .CW(CW)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (cfg_ld),
    .size_i      (cfg_blk_size_i),
    .cnt_i       (cfg_blk_cnt_i),
    .unit_done_i (unit_done),
    .blk_end_i   (blk_end),
    .irq_ack_i   (irq_ack_i),
    .size_o      (blk_size_o),
    .ctr_o       (blk_ctr_o),
    .left_o      (blk_left_o),
    .last_unit_o (last_unit),
    .armed_o     (armed),
    .irq_o       (irq_o)
  );

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_req_o   = (state_q != ST_IDLE);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_addr_o  = (state_q == ST_WR) ? side_addr[1] : side_addr[0];
  assign mem_wdata_o = data_q;
  assign src_addr_o  = side_addr[0];
  assign dst_addr_o  = side_addr[1];

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !(trig_i && armed)) |=> state_q == ST_IDLE);
  a_r9_wdata_from_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD && mem_rdy_i) |=> (mem_we_o && mem_wdata_o == $past(mem_rdata_i)));
  a_r9_wait_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rdy_i) |=> ($stable(mem_addr_o) && $stable(mem_we_o)));
  a_r1_end_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_end |=> !busy_o);
endmodule

// File: tb/blk_xfer_seq_tb.sv
`timescale 1ns/1ps
module blk_xfer_seq_tb;
  typedef struct packed {
    logic [1:0]  unit;
    logic        blk_src;
    logic [1:0]  sdir;
    logic [1:0]  ddir;
    logic [7:0]  size;
    logic [15:0] cnt;
    logic [31:0] src;
    logic [31:0] dst;
    logic [31:0] exp_src;
    logic [31:0] exp_dst;
    logic [31:0] exp_nwr;
    logic [31:0] exp_lra;
    logic [31:0] exp_lwa;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b1, 2'd0, 2'd1, 8'd3, 16'd2, 32'h100, 32'h200, 32'h100, 32'h202, 32'd6, 32'h102, 32'h201},
    '{2'd1, 1'b0, 2'd2, 2'd0, 8'd2, 16'd3, 32'h400, 32'h800, 32'h3FA, 32'h800, 32'd6, 32'h3FC, 32'h802},
    '{2'd2, 1'b1, 2'd0, 2'd0, 8'd1, 16'd1, 32'h040, 32'h080, 32'h040, 32'h080, 32'd1, 32'h040, 32'h080},
    '{2'd2, 1'b0, 2'd1, 2'd1, 8'd4, 16'd2, 32'h1000, 32'h2000, 32'h1008, 32'h2000, 32'd8, 32'h1004, 32'h200C}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_load = 1'b0, blk_src = 1'b0, trig = 1'b0, ack = 1'b0;
  logic [31:0] csrc = '0, cdst = '0;
  logic [1:0]  unit = '0, sdir = '0, ddir = '0;
  logic [7:0]  bsize = '0;
  logic [15:0] bcnt = '0;
  logic        busy, req, we, irq, rdy;
  logic [31:0] addr, wdata, rdata, src_a, dst_a;
  logic [7:0]  size_o, ctr_o;
  logic [15:0] left_o;
  logic        slow = 1'b0, ph = 1'b0;

  int checks = 0, errors = 0;
  int nwr = 0;
  logic [31:0] lra = '0, lwa = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) ph <= ~ph;
  assign rdy   = req & (~slow | ph);
  assign rdata = addr ^ 32'h5A5A_0000;

  blk_xfer_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load),
    .cfg_src_addr_i(csrc), .cfg_dst_addr_i(cdst), .cfg_unit_i(unit),
    .cfg_blk_src_i(blk_src), .cfg_src_dir_i(sdir), .cfg_dst_dir_i(ddir),
    .cfg_blk_size_i(bsize), .cfg_blk_cnt_i(bcnt), .trig_i(trig),
    .busy_o(busy), .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata), .mem_rdy_i(rdy),
    .irq_o(irq), .irq_ack_i(ack), .src_addr_o(src_a), .dst_addr_o(dst_a),
    .blk_size_o(size_o), .blk_ctr_o(ctr_o), .blk_left_o(left_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R9: every completed write carries the data of the preceding read
  always @(negedge clk) begin
    if (rst_n && req && rdy) begin
      if (we) begin
        nwr++;
        lwa = addr;
        chk("R9 write data", wdata, lra ^ 32'h5A5A_0000);
      end else begin
        lra = addr;
      end
    end
  end

  task automatic load(input vec_t v);
    @(negedge clk);
    unit = v.unit; blk_src = v.blk_src; sdir = v.sdir; ddir = v.ddir;
    bsize = v.size; bcnt = v.cnt; csrc = v.src; cdst = v.dst;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    nwr = 0;
  endtask

  task automatic run_blk();
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic clr_irq();
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    chk("R11 busy", 32'(busy), 0);
    chk("R11 req", 32'(req), 0);
    chk("R11 irq", 32'(irq), 0);
    chk("R11 left", 32'(left_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      slow = (i % 2) == 1;
      load(v);
      for (int b = 0; b < int'(v.cnt); b++) begin
        run_blk();
        chk("R5 ctr reload", 32'(ctr_o), 32'(v.size));
        chk("R5 size kept", 32'(size_o), 32'(v.size));
        chk("R8 left", 32'(left_o), 32'(v.cnt) - 32'(b) - 1);
        chk("R10 irq", 32'(irq), (b == int'(v.cnt) - 1) ? 1 : 0);
      end
      chk("R3 R6 R7 src", src_a, v.exp_src);
      chk("R3 R6 R7 dst", dst_a, v.exp_dst);
      chk("R1 R5 units", 32'(nwr), v.exp_nwr);
      chk("R4 last read", lra, v.exp_lra);
      chk("R4 last write", lwa, v.exp_lwa);
      repeat (3) @(negedge clk);
      chk("R10 irq held", 32'(irq), 1);
      clr_irq();
      chk("R10 irq ack", 32'(irq), 0);
    end

    // R5 size 0 = 256 units
    slow = 1'b0;
    load('{2'd0, 1'b1, 2'd0, 2'd1, 8'd0, 16'd1, 32'h0, 32'h300, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0});
    run_blk();
    chk("R5 256 units", 32'(nwr), 256);
    chk("R5 ctr zero", 32'(ctr_o), 0);
    chk("R4 last read", lra, 32'hFF);
    chk("R6 src restore", src_a, 32'h0);
    chk("R7 dst inc", dst_a, 32'h301);
    chk("R10 irq", 32'(irq), 1);
    clr_irq();

    // R2 unarmed after completion: trigger ignored
    nwr = 0;
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 unarmed busy", 32'(busy), 0);
    chk("R2 unarmed writes", 32'(nwr), 0);

    // R8 count 0 = 65536 blocks
    load('{2'd1, 1'b1, 2'd0, 2'd2, 8'd1, 16'd0, 32'h500, 32'h600, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0});
    run_blk();
    chk("R8 65536 left", 32'(left_o), 32'hFFFF);
    chk("R10 no irq", 32'(irq), 0);
    chk("R7 dst dec", dst_a, 32'h5FE);

    // R2 trigger and load while busy ignored
    slow = 1'b1;
    nwr = 0;
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    @(negedge clk) begin trig = 1'b1; cfg_load = 1'b1; csrc = 32'hDEAD; bcnt = 16'd7; end
    @(negedge clk) begin trig = 1'b0; cfg_load = 1'b0; end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R2 busy trig one block", 32'(nwr), 1);
    chk("R2 busy load left", 32'(left_o), 32'hFFFE);
    chk("R2 busy load src", src_a, 32'h500);
    chk("R1 idle after block", 32'(busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule